// File: doc/BRIEF.md
# DRAM Strobe Decoder and Refresh Row Counter

This block is the control logic that sits on the device side of an asynchronous, address-multiplexed DRAM. It is modelled in a synchronous sampling-clock domain. Each clock it samples the row strobe, column strobe, write-enable and output-enable lines, all active low, together with an 11-bit shared address bus. From these it decides what kind of memory cycle is in progress. It captures the row address when the row strobe falls and the column address when the column strobe falls. From this it drives the row-active, column-active, array-write and data-output-enable controls of a storage array. The storage array itself is not part of the block.

The order of the strobe edges selects the cycle type. When the row strobe falls first, a normal access opens. It becomes a read, an early write or a read-modify-write, and further column strobes within the same open row are page-mode accesses. When the column strobe falls first, or is held low from a prior access while the row strobe falls again, a refresh runs. That refresh takes its row from an internal 11-bit counter and ignores the bus. If such a refresh is held long enough, the block enters self-refresh. In self-refresh it refreshes one row at a fixed internal interval until the row strobe returns high.

The finite state machine has seven states:
- `S_IDLE`: both strobes high.
- `S_ROW`: the row is open and the column strobe is high.
- `S_ACC`: the column is active.
- `S_HOLD`: the column strobe is held low with the row strobe high, after an access.
- `S_CBR_ARM`: the column strobe fell first.
- `S_CBR`: counted refresh.
- `S_SELF`: self-refresh.

Its transitions:
- `S_IDLE`→`S_ROW` when the row strobe falls alone.
- `S_IDLE`→`S_CBR_ARM` when the column strobe falls alone.
- `S_IDLE`→`S_CBR` when both strobes fall together.
- `S_ROW`→`S_ACC` when the column strobe falls.
- `S_ROW`→`S_IDLE` when the row strobe rises; this ends a row-only refresh.
- `S_ACC`→`S_ROW` when the column strobe rises; this is the page-mode gap.
- `S_ACC`→`S_HOLD` when the row strobe rises while the column strobe stays low.
- `S_ACC`→`S_IDLE` when both strobes are high.
- `S_HOLD`→`S_CBR` when the row strobe falls again; this is a hidden refresh.
- `S_HOLD`→`S_IDLE` when both strobes are high.
- `S_CBR_ARM`→`S_CBR` when the row strobe falls.
- `S_CBR_ARM`→`S_IDLE` when the column strobe rises.
- `S_CBR`→`S_SELF` when the entry timer expires.
- `S_CBR` and `S_SELF` return to `S_IDLE`, `S_CBR_ARM` or `S_HOLD` when the row strobe rises.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, and in any cycle following a sample with both strobes high, row_act, col_act, arr_we, dq_oe, ref_stb and self_ref are 0 and cyc_kind is 0 (standby).
- R2: When the row strobe is sampled low with the column strobe high from standby, the next cycle shows row_act=1, row_addr equal to the address sampled at that edge, and cyc_kind=1 (row open, no column yet).
- R3: When the column strobe is then sampled low with write-enable high, the next cycle shows col_act=1, col_addr equal to the sampled address, and cyc_kind=3 (read). dq_oe equals the inverse of the current output-enable input.
- R4: If write-enable is low at the column strobe's falling sample, the access is an early write: cyc_kind=4, arr_we=1, and dq_oe=0 even with output-enable low.
- R5: If write-enable falls while a read access is active, the next cycle shows arr_we=1, dq_oe=0 and cyc_kind=5 (read-modify-write).
- R6: If the column strobe rises while the row strobe stays low, cyc_kind=2 (page gap). The next column fall latches a new column while row_addr is held, and page_acc=1 for that second access.
- R7: When the column strobe falls before the row strobe, the cycle after the row strobe falls shows cyc_kind=7, a one-cycle ref_stb pulse with ref_row equal to the refresh counter, row_addr unchanged, and dq_oe=0.
- R8: The refresh counter starts at 0 and advances by one, modulo 2048, after every counted, hidden or self-refresh row. A row-only refresh does not change it.
- R9: If the row strobe rises after a read while the column strobe stays low, cyc_kind=6 and the read data stays enabled. A new row strobe fall then gives cyc_kind=8 (hidden refresh), a ref_stb pulse, and dq_oe kept at 1.
- R10: After SREF_ENTRY_TICKS cycles in a counted refresh, self_ref=1 and cyc_kind=9. A ref_stb pulse then follows every SREF_INTERVAL_TICKS cycles.
- R11: A row strobe sampled high leaves self-refresh, so self_ref is 0 in the next cycle.
- R12: arr_we and dq_oe are never both 1, and col_act is never 1 without row_act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| row_act | output | 1 | Open-row control for the array |
| row_addr | output | ADDR_W | Latched row address |
| col_act | output | 1 | Column-select control |
| col_addr | output | ADDR_W | Latched column address |
| arr_we | output | 1 | Array write strobe |
| dq_oe | output | 1 | Data output driver enable |
| page_acc | output | 1 | Current access is a second or later column in the row |
| ref_stb | output | 1 | One-cycle pulse per counted refresh row |
| ref_row | output | ADDR_W | Row refreshed by the last pulse |
| self_ref | output | 1 | Self-refresh mode active |
| cyc_kind | output | 4 | Cycle class code (0 to 9, as listed in the requirements) |

## Verification
The bench goes after the corner cases that depend on strobe order.

- **Column-first refresh.** The bench drives junk on the bus during this refresh. A design that latched the bus would change row_addr.
- **Hidden refresh.** A design that released the data driver when the row strobe rose would lose the held read data.
- **Read-modify-write.** A late write-enable fall must take over the output. A design that missed it would leave dq_oe asserted next to arr_we.
- **Self-refresh count.** It runs the counter through 2048 rows. This exposes an off-by-one in the entry or interval timers, or a counter that does not wrap.
- **Row-only refresh.** It checks that this refresh leaves the counter alone. A design that counted it would skip a row.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ROW     = 3'd1,
        S_ACC     = 3'd2,
        S_HOLD    = 3'd3,
        S_CBR_ARM = 3'd4,
        S_CBR     = 3'd5,
        S_SELF    = 3'd6
    } dsc_state_e;

    typedef enum logic [3:0] {
        K_STANDBY  = 4'd0,
        K_RAS_ONLY = 4'd1,
        K_PAGE_GAP = 4'd2,
        K_READ     = 4'd3,
        K_EARLY_WR = 4'd4,
        K_RMW      = 4'd5,
        K_CAS_HOLD = 4'd6,
        K_CBR      = 4'd7,
        K_HIDDEN   = 4'd8,
        K_SELF     = 4'd9
    } dsc_kind_e;

endpackage

// File: rtl/dsc_refresh_ctr.sv
module dsc_refresh_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic             ref_stb,
    output logic [ROW_W-1:0] ref_row
);

    logic [ROW_W-1:0] cnt_q;

    // Counter wraps naturally at 2**ROW_W; the row used is reported next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ref_stb <= 1'b0;
            ref_row <= '0;
        end else begin
            ref_stb <= adv;
            if (adv) begin
                ref_row <= cnt_q;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsc_hold_timer.sv
module dsc_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;

    assign hit = run && (cnt_q == (limit - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 16,
    parameter int ENTRY  = 10000,
    parameter int INTV   = 6250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              timer_hit,
    output logic              timer_run,
    output logic [CNT_W-1:0]  timer_limit,
    output logic              ref_adv,
    output logic              row_act,
    output logic [ADDR_W-1:0] row_addr,
    output logic              col_act,
    output logic [ADDR_W-1:0] col_addr,
    output logic              arr_we,
    output logic              dq_oe,
    output logic              page_acc,
    output logic              self_ref,
    output logic [3:0]        cyc_kind
);

    dsc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] row_q, row_d;
    logic [ADDR_W-1:0] col_q, col_d;
    logic              wr_q, wr_d;     // array write in this access
    logic              ewr_q, ewr_d;   // write chosen at column fall
    logic              pg_q, pg_d;     // earlier column already served in this row
    logic              hid_q, hid_d;   // column strobe carried over from an access
    dsc_kind_e         kind;

    // Next state and captured fields
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        col_d   = col_q;
        wr_d    = wr_q;
        ewr_d   = ewr_q;
        pg_d    = pg_q;
        hid_d   = hid_q;
        ref_adv = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                wr_d  = 1'b0;
                ewr_d = 1'b0;
                pg_d  = 1'b0;
                hid_d = 1'b0;
                if (!ras_n && cas_n) begin
                    state_d = S_ROW;
                    row_d   = addr;
                end else if (!ras_n && !cas_n) begin
                    state_d = S_CBR;
                    ref_adv = 1'b1;
                end else if (!cas_n) begin
                    state_d = S_CBR_ARM;
                end
            end
            S_ROW: begin
                if (ras_n) begin
                    state_d = cas_n ? S_IDLE : S_CBR_ARM;
                end else if (!cas_n) begin
                    state_d = S_ACC;
                    col_d   = addr;
                    wr_d    = !we_n;
                    ewr_d   = !we_n;
                end
            end
            S_ACC: begin
                if (ras_n) begin
                    if (!cas_n) begin
                        state_d = S_HOLD;
                        hid_d   = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else if (cas_n) begin
                    state_d = S_ROW;
                    pg_d    = 1'b1;
                end else if (!we_n) begin
                    wr_d = 1'b1;
                end
            end
            S_HOLD: begin
                if (!ras_n) begin
                    if (!cas_n) begin
                        state_d = S_CBR;
                        ref_adv = 1'b1;
                    end else begin
                        state_d = S_ROW;
                        row_d   = addr;
                        wr_d    = 1'b0;
                        ewr_d   = 1'b0;
                        pg_d    = 1'b0;
                        hid_d   = 1'b0;
                    end
                end else if (cas_n) begin
                    state_d = S_IDLE;
                end
            end
            S_CBR_ARM: begin
                wr_d  = 1'b0;
                ewr_d = 1'b0;
                pg_d  = 1'b0;
                hid_d = 1'b0;
                if (!ras_n) begin
                    state_d = S_CBR;
                    ref_adv = 1'b1;
                end else if (cas_n) begin
                    state_d = S_IDLE;
                end
            end
            S_CBR: begin
                if (ras_n) begin
                    if (cas_n) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d = hid_q ? S_HOLD : S_CBR_ARM;
                    end
                end else if (timer_hit) begin
                    state_d = S_SELF;
                end
            end
            S_SELF: begin
                if (ras_n) begin
                    state_d = cas_n ? S_IDLE : S_CBR_ARM;
                end else if (timer_hit) begin
                    ref_adv = 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            ewr_q   <= 1'b0;
            pg_q    <= 1'b0;
            hid_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            col_q   <= col_d;
            wr_q    <= wr_d;
            ewr_q   <= ewr_d;
            pg_q    <= pg_d;
            hid_q   <= hid_d;
        end
    end

    // Outputs
    always_comb begin
        row_act     = 1'b0;
        col_act     = 1'b0;
        arr_we      = 1'b0;
        dq_oe       = 1'b0;
        page_acc    = 1'b0;
        self_ref    = 1'b0;
        timer_run   = 1'b0;
        timer_limit = CNT_W'(INTV);
        kind        = K_STANDBY;
        unique case (state_q)
            S_IDLE: begin
                kind = K_STANDBY;
            end
            S_ROW: begin
                row_act = 1'b1;
                kind    = pg_q ? K_PAGE_GAP : K_RAS_ONLY;
            end
            S_ACC: begin
                row_act  = 1'b1;
                col_act  = 1'b1;
                arr_we   = wr_q;
                page_acc = pg_q;
                dq_oe    = !oe_n && !wr_q;
                if (ewr_q) begin
                    kind = K_EARLY_WR;
                end else if (wr_q) begin
                    kind = K_RMW;
                end else begin
                    kind = K_READ;
                end
            end
            S_HOLD: begin
                dq_oe = !oe_n && !wr_q;
                kind  = K_CAS_HOLD;
            end
            S_CBR_ARM: begin
                kind = K_STANDBY;
            end
            S_CBR: begin
                timer_run   = 1'b1;
                timer_limit = CNT_W'(ENTRY);
                dq_oe       = hid_q && !oe_n && !wr_q;
                kind        = hid_q ? K_HIDDEN : K_CBR;
            end
            S_SELF: begin
                timer_run = 1'b1;
                self_ref  = 1'b1;
                kind      = K_SELF;
            end
            default: begin
                kind = K_STANDBY;
            end
        endcase
    end

    assign row_addr = row_q;
    assign col_addr = col_q;
    assign cyc_kind = kind;

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
    parameter int ADDR_W              = 11,
    parameter int SREF_ENTRY_TICKS    = 10000,
    parameter int SREF_INTERVAL_TICKS = 6250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              row_act,
    output logic [ADDR_W-1:0] row_addr,
    output logic              col_act,
    output logic [ADDR_W-1:0] col_addr,
    output logic              arr_we,
    output logic              dq_oe,
    output logic              page_acc,
    output logic              ref_stb,
    output logic [ADDR_W-1:0] ref_row,
    output logic              self_ref,
    output logic [3:0]        cyc_kind
);

    localparam int MAX_TICKS = (SREF_ENTRY_TICKS > SREF_INTERVAL_TICKS) ?
                               SREF_ENTRY_TICKS : SREF_INTERVAL_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             timer_run;
    logic             timer_hit;
    logic [CNT_W-1:0] timer_limit;
    logic             ref_adv;

    dsc_fsm #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .ENTRY  (SREF_ENTRY_TICKS),
        .INTV   (SREF_INTERVAL_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .addr        (addr),
        .timer_hit   (timer_hit),
        .timer_run   (timer_run),
        .timer_limit (timer_limit),
        .ref_adv     (ref_adv),
        .row_act     (row_act),
        .row_addr    (row_addr),
        .col_act     (col_act),
        .col_addr    (col_addr),
        .arr_we      (arr_we),
        .dq_oe       (dq_oe),
        .page_acc    (page_acc),
        .self_ref    (self_ref),
        .cyc_kind    (cyc_kind)
    );

    dsc_hold_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .limit (timer_limit),
        .hit   (timer_hit)
    );

    dsc_refresh_ctr #(
        .ROW_W (ADDR_W)
    ) u_ref_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (ref_adv),
        .ref_stb (ref_stb),
        .ref_row (ref_row)
    );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              row_act,
    input logic              col_act,
    input logic              arr_we,
    input logic              dq_oe,
    input logic              ref_stb,
    input logic [ADDR_W-1:0] ref_row,
    input logic              self_ref,
    input logic [3:0]        cyc_kind
);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (ref_stb) begin
            seen_q <= 1'b1;
            last_q <= ref_row;
        end
    end

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n && cas_n) |-> (!row_act && !col_act && !dq_oe && !arr_we && !self_ref));

    p_refresh_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == K_CBR || cyc_kind == K_RAS_ONLY || cyc_kind == K_SELF) |-> !dq_oe);

    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && seen_q) |-> (ref_row == last_q + 1'b1));

    p_self_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ras_n) |-> !self_ref);

    p_we_oe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && dq_oe));

    p_col_in_row_r12: assert property (@(posedge clk) disable iff (!rst_n)
        col_act |-> row_act);

endmodule

bind dram_strobe_ctrl dsc_checker #(.ADDR_W(ADDR_W)) u_dsc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_act  (row_act),
    .col_act  (col_act),
    .arr_we   (arr_we),
    .dq_oe    (dq_oe),
    .ref_stb  (ref_stb),
    .ref_row  (ref_row),
    .self_ref (self_ref),
    .cyc_kind (cyc_kind)
);

// File: tb/dram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_tb_top;

    localparam int AW    = 11;
    localparam int ENTRY = 12;
    localparam int INTV  = 3;
    localparam int NROWS = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          row_act, col_act, arr_we, dq_oe, page_acc, ref_stb, self_ref;
    logic [AW-1:0] row_addr, col_addr, ref_row;
    logic [3:0]    cyc_kind;

    int n_chk = 0;
    int n_fail = 0;
    int exp_ref = 0;

    logic [3:0] wdata = '0;
    logic [3:0] arr_mem [64];
    logic [3:0] exp_mem [64];

    always #5 clk = ~clk;

    dram_strobe_ctrl #(
        .ADDR_W              (AW),
        .SREF_ENTRY_TICKS    (ENTRY),
        .SREF_INTERVAL_TICKS (INTV)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .oe_n (oe_n), .addr (addr),
        .row_act (row_act), .row_addr (row_addr), .col_act (col_act),
        .col_addr (col_addr), .arr_we (arr_we), .dq_oe (dq_oe),
        .page_acc (page_acc), .ref_stb (ref_stb), .ref_row (ref_row),
        .self_ref (self_ref), .cyc_kind (cyc_kind)
    );

    // Behavioural array standing in for the storage cells
    initial begin
        for (int i = 0; i < 64; i++) arr_mem[i] = '0;
    end
    always @(posedge clk) begin
        if (arr_we) arr_mem[{row_addr[2:0], col_addr[2:0]}] <= wdata;
    end

    function automatic int idx_of(input logic [AW-1:0] r, input logic [AW-1:0] c);
        return int'({r[2:0], c[2:0]});
    endfunction

    function automatic int exp_row();
        return exp_ref % NROWS;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        @(negedge clk);
    endtask

    task automatic idle();
        drv(1, 1, 1, 1, '0);
    endtask

    task automatic wr_cyc(input logic [AW-1:0] r, input logic [AW-1:0] c,
                          input logic [3:0] d);
        wdata = d;
        drv(0, 1, 1, 1, r);
        drv(0, 0, 0, 0, c);
        chk("R4 early write kind", cyc_kind, 4);
        chk("R4 arr_we", arr_we, 1);
        chk("R4 dq_oe off", dq_oe, 0);
        drv(0, 0, 0, 1, c);
        exp_mem[idx_of(r, c)] = d;
        idle();
    endtask

    task automatic rd_cyc(input logic [AW-1:0] r, input logic [AW-1:0] c);
        drv(0, 1, 1, 1, r);
        chk("R2 row_act", row_act, 1);
        chk("R2 row_addr", row_addr, r);
        chk("R2 kind", cyc_kind, 1);
        drv(0, 0, 1, 0, c);
        chk("R3 col_addr", col_addr, c);
        chk("R3 kind", cyc_kind, 3);
        chk("R3 dq_oe", dq_oe, 1);
        chk("R3 read data", arr_mem[idx_of(r, c)], exp_mem[idx_of(r, c)]);
        idle();
        chk("R1 standby kind", cyc_kind, 0);
        chk("R1 dq_oe off", dq_oe, 0);
    endtask

    task automatic cbr_cyc();
        drv(1, 0, 1, 0, 11'h5A5);
        drv(0, 0, 1, 0, 11'h2C3);
        chk("R7 kind", cyc_kind, 7);
        chk("R7 ref_stb", ref_stb, 1);
        chk("R8 ref_row", ref_row, exp_row());
        chk("R7 dq_oe off", dq_oe, 0);
        exp_ref++;
        drv(0, 0, 1, 0, 11'h111);
        chk("R7 single pulse", ref_stb, 0);
        idle();
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] r0;
        logic [AW-1:0] c0;
        int errs;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset kind", cyc_kind, 0);
        chk("R1 reset row_act", row_act, 0);
        chk("R1 reset ref_stb", ref_stb, 0);
        chk("R1 reset self_ref", self_ref, 0);

        // R2/R3/R4 basic write and read
        wr_cyc(11'h123, 11'h045, 4'hA);
        rd_cyc(11'h123, 11'h045);

        // R5 read-modify-write
        drv(0, 1, 1, 1, 11'h00A);
        drv(0, 0, 1, 0, 11'h003);
        chk("R5 read phase dq_oe", dq_oe, 1);
        wdata = 4'h6;
        drv(0, 0, 0, 1, 11'h003);
        chk("R5 kind", cyc_kind, 5);
        chk("R5 arr_we", arr_we, 1);
        chk("R5 dq_oe off", dq_oe, 0);
        drv(0, 0, 0, 1, 11'h003);
        exp_mem[idx_of(11'h00A, 11'h003)] = 4'h6;
        idle();
        rd_cyc(11'h00A, 11'h003);

        // R6 page mode
        wr_cyc(11'h301, 11'h006, 4'h3);
        drv(0, 1, 1, 1, 11'h301);
        drv(0, 0, 1, 0, 11'h045);
        chk("R6 first page_acc", page_acc, 0);
        drv(0, 1, 1, 1, 11'h7FF);
        chk("R6 gap kind", cyc_kind, 2);
        drv(0, 0, 1, 0, 11'h006);
        chk("R6 page_acc", page_acc, 1);
        chk("R6 col_addr", col_addr, 11'h006);
        chk("R6 row held", row_addr, 11'h301);
        chk("R6 page data", arr_mem[idx_of(11'h301, 11'h006)], 3);
        idle();

        // R8 row-only refresh leaves counter; R7 bus ignored
        drv(0, 1, 1, 1, 11'h0F0);
        chk("R8 row-only kind", cyc_kind, 1);
        chk("R8 row-only no pulse", ref_stb, 0);
        idle();
        cbr_cyc();
        chk("R7 row_addr unchanged", row_addr, 11'h0F0);

        // R9 hidden refresh after a read
        drv(0, 1, 1, 1, 11'h123);
        drv(0, 0, 1, 0, 11'h045);
        drv(1, 0, 1, 0, 11'h000);
        chk("R9 hold kind", cyc_kind, 6);
        chk("R9 hold dq_oe", dq_oe, 1);
        chk("R9 hold data", arr_mem[idx_of(11'h123, 11'h045)], 4'hA);
        drv(0, 0, 1, 0, 11'h3AB);
        chk("R9 hidden kind", cyc_kind, 8);
        chk("R9 hidden pulse", ref_stb, 1);
        chk("R9 hidden row", ref_row, exp_row());
        chk("R9 hidden dq_oe", dq_oe, 1);
        exp_ref++;
        drv(1, 0, 1, 0, 11'h000);
        chk("R9 back to hold", cyc_kind, 6);
        idle();

        // Random mix of cycles
        for (int n = 0; n < 40; n++) begin
            int op;
            op = $urandom_range(0, 3);
            r0 = AW'($urandom);
            c0 = AW'($urandom);
            case (op)
                0: wr_cyc(r0, c0, 4'($urandom));
                1: rd_cyc(r0, c0);
                2: begin
                    drv(0, 1, 1, 1, r0);
                    chk("R8 random row-only", ref_stb, 0);
                    idle();
                end
                default: cbr_cyc();
            endcase
        end

        // R10 self-refresh entry and R8 wrap
        drv(1, 0, 1, 1, '0);
        drv(0, 0, 1, 1, '0);
        chk("R10 entry pulse row", ref_row, exp_row());
        exp_ref++;
        repeat (ENTRY - 1) drv(0, 0, 1, 1, '0);
        chk("R10 not yet self", self_ref, 0);
        drv(0, 0, 1, 1, '0);
        chk("R10 self_ref", self_ref, 1);
        chk("R10 self kind", cyc_kind, 9);
        errs = 0;
        for (int p = 0; p < NROWS + 2; p++) begin
            repeat (INTV - 1) begin
                drv(0, 0, 1, 1, '0);
                if (ref_stb !== 1'b0) errs++;
            end
            drv(0, 0, 1, 1, '0);
            if (ref_stb !== 1'b1 || int'(ref_row) != exp_row()) errs++;
            exp_ref++;
        end
        chk("R10 interval pulses", errs, 0);
        chk("R8 wrap row", ref_row, (exp_ref - 1) % NROWS);

        // R11 exit
        idle();
        chk("R11 self_ref cleared", self_ref, 0);
        chk("R11 standby kind", cyc_kind, 0);
        cbr_cyc();

        // R12 spot check
        drv(0, 1, 1, 1, 11'h001);
        drv(0, 0, 0, 0, 11'h002);
        chk("R12 no dq during write", dq_oe, 0);
        idle();

        summary();
        $finish;
    end

endmodule